// File: doc/BRIEF.md
# Configuration command block encoder

The encoder turns one configuration command into a framed, byte-serial block. A command code, a declared payload length and a trailer shape are captured when a start request is accepted. The block then goes out as: the command byte, the length field, a two-byte header checksum, the payload bytes taken from a byte-serial source, and a two-byte checksum over the whole block. An optional trailer of no-op bytes, which may contain one execute byte, can follow the block checksum.

The length field is one byte for every command code except one. For that code (0xD2 by default) the field is two bytes wide and sent low byte first. Both checksums are CRC-16 and are sent high byte first. A single checksum register runs from the command byte through the payload, so the block checksum also covers the two header checksum bytes as they were sent. The output is a valid/ready stream. Backpressure stalls the encoder without losing or repeating a byte. If the payload source runs short, the encoder waits for it.

Top module: `cfg_block_enc`

## Requirements
- R1: While reset is asserted and while idle afterwards, `out_valid_o`, `pl_ready_o` and `busy_o` are all 0.
- R2: A start request is accepted only while `busy_o` is 0. The command, length and trailer inputs are captured at acceptance. A start request made while busy has no effect on the block being sent. `busy_o` returns to 0 in the cycle after the last byte of the block has been transferred.
- R3: The bytes go out in this order: command byte, length field, header CRC high byte, header CRC low byte, payload bytes in arrival order, block CRC high byte, block CRC low byte, trailer.
- R4: For command 0xD2 the length field is two bytes, `len_i[7:0]` then `len_i[15:8]`, and the payload count is `len_i`. For any other command the field is the single byte `len_i[7:0]` and the payload count is `len_i[7:0]`.
- R5: Each CRC is CRC-16 with polynomial 0x1021 processed bit-reflected (LSB first, shift constant 0x8408), initial value 0xFFFF and final XOR 0xFFFF. The check value over ASCII "123456789" is 0x906E. The header CRC covers the command and length bytes.
- R6: The block CRC carries on the same register without re-seeding. It covers the command byte, the length bytes, the two header CRC bytes as sent, and the payload.
- R7: The trailer is `lead_nops_i` bytes of 0x00, then one byte 0x33 if `exec_en_i` is 1, then `tail_nops_i` bytes of 0x00. Each count runs from 0 to 15.
- R8: When `out_valid_o` is 1 and `out_ready_i` is 0, the next cycle still shows `out_valid_o` = 1 with the same `out_data_o`, provided the payload source holds its own offer.
- R9: `pl_ready_o` is 1 only during the payload phase and only when `out_ready_i` is 1. While the payload is incomplete and `pl_valid_i` is 0, `out_valid_o` is 0.
- R10: A payload count of zero goes straight from the header CRC low byte to the block CRC high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one block |
| cmd_i | input | 8 | Command code |
| len_i | input | 16 | Declared payload length |
| lead_nops_i | input | 4 | Number of 0x00 bytes before the execute byte |
| exec_en_i | input | 1 | Append the execute byte 0x33 |
| tail_nops_i | input | 4 | Number of 0x00 bytes after the execute byte |
| busy_o | output | 1 | A block is being sent |
| pl_valid_i | input | 1 | Payload byte offered |
| pl_data_i | input | 8 | Payload byte |
| pl_ready_o | output | 1 | Payload byte taken this cycle when valid |
| out_valid_o | output | 1 | Output byte offered |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts the byte |

## Verification
The stall-hold property is checked only outside the payload phase. Inside the payload phase the output byte is the payload source's own byte, and nothing in the block forces that source to keep it steady. The bench therefore models a well-behaved source: once it raises `pl_valid_i` it keeps the same byte offered until that byte is taken, and it only opens gaps before raising valid. The bench also never asserts reset mid-block. Under those conditions every assertion holds from reset, and the bench's port-level stall checks apply to payload bytes as well.

// File: rtl/cfg_enc_pkg.sv
package cfg_enc_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_LEN_LO,
    ST_LEN_HI,
    ST_HCRC_HI,
    ST_HCRC_LO,
    ST_PAY,
    ST_BCRC_HI,
    ST_BCRC_LO,
    ST_LEAD,
    ST_EXEC,
    ST_TAIL
  } enc_state_e;

  function automatic logic [CRC_W-1:0] bitrev16(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // one byte through a reflected CRC register, LSB first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d,
                                                input logic [CRC_W-1:0] poly_rev);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-BYTE_W){1'b0}}, d};
    for (int i = 0; i < BYTE_W; i++) r = r[0] ? ((r >> 1) ^ poly_rev) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/cfg_enc_crc.sv
module cfg_enc_crc
  import cfg_enc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0] INIT   = 16'hFFFF,
  parameter logic [CRC_W-1:0] XOROUT = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              snap_ld_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic [CRC_W-1:0]  snap_o
);

  localparam logic [CRC_W-1:0] POLY_REV = bitrev16(POLY);

  logic [CRC_W-1:0] crc_q, crc_upd, snap_q;

  assign crc_upd = crc_step(crc_q, data_i, POLY_REV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= INIT;
    end else if (clr_i) begin
      crc_q <= INIT;
    end else if (en_i) begin
      crc_q <= crc_upd;
    end
  end

  // frozen finished value, so both bytes go out unchanged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
    end else if (snap_ld_i) begin
      snap_q <= crc_upd ^ XOROUT;
    end
  end

  assign crc_o  = crc_q;
  assign snap_o = snap_q;

  AST_SNAP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_ld_i |-> en_i && !clr_i); // R6

endmodule

// File: rtl/cfg_enc_fsm.sv
module cfg_enc_fsm
  import cfg_enc_pkg::*;
#(
  parameter int                LEN_W    = 16,
  parameter int                ZCNT_W   = 4,
  parameter logic [BYTE_W-1:0] WIDE_CMD = 8'hD2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ZCNT_W-1:0] lead_i,
  input  logic              exec_i,
  input  logic [ZCNT_W-1:0] tail_i,
  input  logic              hs_i,
  output enc_state_e        state_o,
  output enc_state_e        state_d_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [LEN_W-1:0]  len_o
);

  localparam int SHORT_W = BYTE_W;

  enc_state_e        state_q, state_d, after_crc, after_lead, after_exec;
  logic [BYTE_W-1:0] cmd_q;
  logic [LEN_W-1:0]  len_q, pay_len, cnt_q, cnt_d;
  logic [ZCNT_W-1:0] lead_q, tail_q;
  logic              exec_q, wide_q;

  assign pay_len = wide_q ? len_q : LEN_W'(len_q[SHORT_W-1:0]);

  // trailer sequencing; empty segments are skipped
  assign after_exec = (tail_q != '0) ? ST_TAIL : ST_IDLE;
  assign after_lead = exec_q ? ST_EXEC : after_exec;
  assign after_crc  = (lead_q != '0) ? ST_LEAD : after_lead;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CMD;
      ST_CMD:     if (hs_i) state_d = ST_LEN_LO;
      ST_LEN_LO:  if (hs_i) state_d = wide_q ? ST_LEN_HI : ST_HCRC_HI;
      ST_LEN_HI:  if (hs_i) state_d = ST_HCRC_HI;
      ST_HCRC_HI: if (hs_i) state_d = ST_HCRC_LO;
      ST_HCRC_LO: begin
        if (hs_i) begin
          if (pay_len == '0) begin
            state_d = ST_BCRC_HI;
          end else begin
            state_d = ST_PAY;
            cnt_d   = pay_len;
          end
        end
      end
      ST_PAY: begin
        if (hs_i) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) state_d = ST_BCRC_HI;
        end
      end
      ST_BCRC_HI: if (hs_i) state_d = ST_BCRC_LO;
      ST_BCRC_LO: begin
        if (hs_i) begin
          state_d = after_crc;
          cnt_d   = (after_crc == ST_LEAD) ? LEN_W'(lead_q) : LEN_W'(tail_q);
        end
      end
      ST_LEAD: begin
        if (hs_i) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) begin
            state_d = after_lead;
            cnt_d   = LEN_W'(tail_q);
          end
        end
      end
      ST_EXEC: begin
        if (hs_i) begin
          state_d = after_exec;
          cnt_d   = LEN_W'(tail_q);
        end
      end
      ST_TAIL: begin
        if (hs_i) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      len_q  <= '0;
      lead_q <= '0;
      tail_q <= '0;
      exec_q <= 1'b0;
      wide_q <= 1'b0;
    end else if (state_q == ST_IDLE && start_i) begin
      cmd_q  <= cmd_i;
      len_q  <= len_i;
      lead_q <= lead_i;
      tail_q <= tail_i;
      exec_q <= exec_i;
      wide_q <= (cmd_i == WIDE_CMD);
    end
  end

  assign state_o   = state_q;
  assign state_d_o = state_d;
  assign cmd_o     = cmd_q;
  assign len_o     = len_q;

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(cmd_q) && $stable(len_q) && $stable(lead_q)); // R2
  AST_NARROW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEN_HI) |-> (cmd_q == WIDE_CMD)); // R4
  AST_PAY_CNT_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAY) |-> (cnt_q != '0) && (cnt_q <= pay_len)); // R4
  AST_RUN_CNT_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEAD || state_q == ST_TAIL) |-> (cnt_q != '0)); // R7
  AST_ZERO_LEN_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_i && state_q == ST_HCRC_LO && pay_len == '0) |=> (state_q == ST_BCRC_HI)); // R10

endmodule

// File: rtl/cfg_block_enc.sv
module cfg_block_enc
  import cfg_enc_pkg::*;
#(
  parameter int                LEN_W     = 16,
  parameter int                ZCNT_W    = 4,
  parameter logic [BYTE_W-1:0] WIDE_CMD  = 8'hD2,
  parameter logic [BYTE_W-1:0] EXEC_BYTE = 8'h33,
  parameter logic [BYTE_W-1:0] NOP_BYTE  = 8'h00,
  parameter logic [CRC_W-1:0]  CRC_POLY  = 16'h1021,
  parameter logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF,
  parameter logic [CRC_W-1:0]  CRC_XOR   = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ZCNT_W-1:0] lead_nops_i,
  input  logic              exec_en_i,
  input  logic [ZCNT_W-1:0] tail_nops_i,
  output logic              busy_o,
  input  logic              pl_valid_i,
  input  logic [BYTE_W-1:0] pl_data_i,
  output logic              pl_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i
);

  localparam int HALF_W = CRC_W / 2;

  enc_state_e        state_q, state_d;
  logic [BYTE_W-1:0] cmd_q;
  logic [LEN_W-1:0]  len_q;
  logic [CRC_W-1:0]  crc_q, snap_q;
  logic              hs, crc_en, snap_ld, in_crc_span;

  cfg_enc_fsm #(
    .LEN_W   (LEN_W),
    .ZCNT_W  (ZCNT_W),
    .WIDE_CMD(WIDE_CMD)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cmd_i    (cmd_i),
    .len_i    (len_i),
    .lead_i   (lead_nops_i),
    .exec_i   (exec_en_i),
    .tail_i   (tail_nops_i),
    .hs_i     (hs),
    .state_o  (state_q),
    .state_d_o(state_d),
    .cmd_o    (cmd_q),
    .len_o    (len_q)
  );

  always_comb begin
    unique case (state_q)
      ST_CMD, ST_LEN_LO, ST_LEN_HI,
      ST_HCRC_HI, ST_HCRC_LO, ST_PAY: in_crc_span = 1'b1;
      default:                        in_crc_span = 1'b0;
    endcase
  end

  assign hs      = out_valid_o && out_ready_i;
  assign crc_en  = hs && in_crc_span;
  assign snap_ld = hs && (state_d == ST_HCRC_HI || state_d == ST_BCRC_HI);

  cfg_enc_crc #(
    .POLY  (CRC_POLY),
    .INIT  (CRC_INIT),
    .XOROUT(CRC_XOR)
  ) u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_IDLE),
    .en_i     (crc_en),
    .snap_ld_i(snap_ld),
    .data_i   (out_data_o),
    .crc_o    (crc_q),
    .snap_o   (snap_q)
  );

  always_comb begin
    unique case (state_q)
      ST_CMD:                  out_data_o = cmd_q;
      ST_LEN_LO:               out_data_o = len_q[BYTE_W-1:0];
      ST_LEN_HI:               out_data_o = len_q[2*BYTE_W-1:BYTE_W];
      ST_HCRC_HI, ST_BCRC_HI:  out_data_o = snap_q[CRC_W-1:HALF_W];
      ST_HCRC_LO, ST_BCRC_LO:  out_data_o = snap_q[HALF_W-1:0];
      ST_PAY:                  out_data_o = pl_data_i;
      ST_EXEC:                 out_data_o = EXEC_BYTE;
      default:                 out_data_o = NOP_BYTE;
    endcase
  end

  assign out_valid_o = (state_q != ST_IDLE) && ((state_q != ST_PAY) || pl_valid_i);
  assign pl_ready_o  = (state_q == ST_PAY) && out_ready_i;
  assign busy_o      = (state_q != ST_IDLE);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o && !pl_ready_o); // R1
  AST_CRC_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD) |-> (crc_q == CRC_INIT)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && state_q != ST_PAY)
      |=> out_valid_o && $stable(out_data_o)); // R8
  AST_PAY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_ready_o |-> out_ready_i && busy_o); // R9
  AST_PAY_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_ready_o && !pl_valid_i) |-> !out_valid_o); // R9
  AST_CRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BCRC_LO) |-> $stable(crc_q)); // R6

endmodule

// File: tb/tb_cfg_block_enc.sv
module tb_cfg_block_enc;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [15:0] len;
    logic [3:0]  lead;
    logic        ex;
    logic [3:0]  tail;
    logic [3:0]  rmod;
    logic [3:0]  vmod;
    logic        poke;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'hD9, 16'd1,      4'd0,  1'b0, 4'd0,  4'd0, 4'd0, 1'b0},
    '{8'hD2, 16'd300,    4'd2,  1'b1, 4'd2,  4'd3, 4'd0, 1'b0},
    '{8'hC5, 16'd0,      4'd0,  1'b0, 4'd0,  4'd0, 4'd0, 1'b1},
    '{8'hCA, 16'h01FF,   4'd0,  1'b0, 4'd1,  4'd0, 4'd5, 1'b0},
    '{8'hD2, 16'd0,      4'd0,  1'b1, 4'd0,  4'd2, 4'd0, 1'b0},
    '{8'hD2, 16'd5,      4'd15, 1'b1, 4'd15, 4'd2, 4'd3, 1'b1},
    '{8'hC9, 16'd4,      4'd3,  1'b0, 4'd2,  4'd4, 4'd2, 1'b0},
    '{8'hDC, 16'd2,      4'd0,  1'b0, 4'd0,  4'd0, 4'd0, 1'b0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, start, exec_en, busy, pl_valid, pl_ready, out_valid, out_ready;
  logic [7:0] cmd, pl_data, out_data;
  logic [15:0] len;
  logic [3:0] lead_n, tail_n;

  cfg_block_enc dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .len_i(len),
    .lead_nops_i(lead_n), .exec_en_i(exec_en), .tail_nops_i(tail_n), .busy_o(busy),
    .pl_valid_i(pl_valid), .pl_data_i(pl_data), .pl_ready_o(pl_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_b [0:1023];
  string      exp_t [0:1023];
  int         exp_n;
  logic [15:0] mcrc;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] m_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] pay_byte(input logic [7:0] c, input int i);
    return 8'(i * 13) + c;
  endfunction

  function automatic int pay_count(input vec_t v);
    return (v.cmd == 8'hD2) ? int'(v.len) : int'(v.len[7:0]);
  endfunction

  task automatic push(input logic [7:0] b, input string tag, input bit crc_on);
    exp_b[exp_n] = b;
    exp_t[exp_n] = tag;
    exp_n++;
    if (crc_on) mcrc = m_step(mcrc, b);
  endtask

  task automatic build(input vec_t v);
    logic [15:0] f;
    exp_n = 0;
    mcrc  = 16'hFFFF;
    push(v.cmd, "R3 cmd", 1'b1);
    push(v.len[7:0], "R4 len", 1'b1);
    if (v.cmd == 8'hD2) push(v.len[15:8], "R4 len_hi", 1'b1);
    f = mcrc ^ 16'hFFFF;
    push(f[15:8], "R5 hdr_crc", 1'b1);
    push(f[7:0],  "R5 hdr_crc", 1'b1);
    for (int i = 0; i < pay_count(v); i++) push(pay_byte(v.cmd, i), "R3 payload", 1'b1);
    f = mcrc ^ 16'hFFFF;
    push(f[15:8], (pay_count(v) == 0) ? "R10 blk_crc" : "R6 blk_crc", 1'b0);
    push(f[7:0],  "R6 blk_crc", 1'b0);
    for (int i = 0; i < int'(v.lead); i++) push(8'h00, "R7 lead", 1'b0);
    if (v.ex) push(8'h33, "R7 exec", 1'b0);
    for (int i = 0; i < int'(v.tail); i++) push(8'h00, "R7 tail", 1'b0);
  endtask

  task automatic run_vec(input vec_t v);
    int cyc, got, pidx, npay;
    bit consumed, prev_stall;
    logic [7:0] prev_data;
    build(v);
    npay = pay_count(v);
    @(negedge clk);
    start = 1'b1; cmd = v.cmd; len = v.len;
    lead_n = v.lead; exec_en = v.ex; tail_n = v.tail;
    pl_valid = 1'b0; out_ready = 1'b0;
    #1 chk(!busy, "R2", "idle before start", int'(busy), 0);
    @(negedge clk);
    start = 1'b0;
    cyc = 0; got = 0; pidx = 0; consumed = 1'b0; prev_stall = 1'b0; prev_data = '0;
    while (got < exp_n && cyc < 20000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (consumed) begin pidx++; pl_valid = 1'b0; consumed = 1'b0; end
      out_ready = (v.rmod == 0) ? 1'b1 : ((cyc % int'(v.rmod)) != 0);
      if (!pl_valid && pidx < npay)
        pl_valid = (v.vmod == 0) ? 1'b1 : ((cyc % int'(v.vmod)) == 0);
      pl_data = pay_byte(v.cmd, pidx);
      start = v.poke && (cyc == 3);
      if (start) begin cmd = 8'hC1; len = 16'd7; lead_n = 4'd1; end
      #1;
      if (start) chk(busy, "R2", "busy when start poked", int'(busy), 1);
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R8", "stalled byte held",
            int'(out_data), int'(prev_data));
      if (pl_ready) chk(out_ready, "R9", "pl_ready without out_ready", 0, 1);
      if (pl_ready && !pl_valid)
        chk(!out_valid, "R9", "valid during payload gap", int'(out_valid), 0);
      if (out_valid && out_ready) begin
        chk(out_data == exp_b[got], exp_t[got], $sformatf("byte %0d", got),
            int'(out_data), int'(exp_b[got]));
        got++;
      end
      if (pl_valid && pl_ready) consumed = 1'b1;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
    chk(got == exp_n, "R3", "block byte count", got, exp_n);
    @(negedge clk);
    start = 1'b0; pl_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(!busy && !out_valid, "R2", "idle after last byte", int'({busy, out_valid}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] cv;
    rst_n = 1'b0; start = 1'b0; cmd = '0; len = '0; lead_n = '0; tail_n = '0;
    exec_en = 1'b0; pl_valid = 1'b0; pl_data = '0; out_ready = 1'b1;

    // R5: model check value
    cv = 16'hFFFF;
    for (int i = 0; i < 9; i++) cv = m_step(cv, 8'h31 + 8'(i));
    cv = cv ^ 16'hFFFF;
    chk(cv == 16'h906E, "R5", "crc check value", int'(cv), 16'h906E);

    // R1: reset state, start held high during reset
    start = 1'b1; cmd = 8'hD9;
    repeat (3) @(negedge clk);
    #1 chk(!out_valid && !pl_ready && !busy, "R1", "outputs in reset",
           int'({busy, pl_ready, out_valid}), 0);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk(!out_valid && !pl_ready && !busy, "R1", "outputs after reset",
           int'({busy, pl_ready, out_valid}), 0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10 across vectors
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

    // R8 directed: long stall on command byte
    @(negedge clk);
    start = 1'b1; cmd = 8'hC3; len = 16'd0; lead_n = 0; exec_en = 0; tail_n = 0;
    out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    #1 chk(out_valid && out_data == 8'hC3, "R8", "cmd byte after 10 stalled cycles",
           int'(out_data), 8'hC3);
    build(VECS[0]);
    for (int j = 0; j < 30 && busy; j++) begin
      @(negedge clk);
      out_ready = 1'b1;
    end
    @(negedge clk);
    #1 chk(!busy, "R2", "stalled block drains", int'(busy), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule